// File: doc/BRIEF.md
# Circular Delay-Line Address Sequencer

This block drives an external word-wide sample memory as a circular buffer for a mono audio delay. Each accepted sample strobe moves a write pointer forward by one word, stores the incoming 16-bit sample there, and then fetches the delayed sample. The fetch address is the write address of the same period minus the delay length. The fetched word goes to both the left and the right output.

After reset the block first fills the buffer with zeros, one word per clock, so a long delay does not play out stale memory contents. A busy flag stays high for the whole fill. Strobes that arrive during the fill are dropped. The delay length is an input port. It is sampled at the close of each sample period, and the next period's read address is formed from it, so a change to the delay takes effect one period later.

The memory port is synchronous. Writes take effect at the clock edge where the write enable is high. Read data appears one clock after the address is presented.

Top module: `dl_delay_seq`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `busy` is 1 and both outputs are 0.
- R2: After reset the block writes 0 to every address from 1 to 2^ADDR_W-1, one address per clock in ascending order, with address 0 left untouched. `busy` falls in the cycle after the last of those writes.
- R3: A strobe that arrives while `busy` is high is ignored and does not move the pointers.
- R4: The write address of the first accepted sample after the fill is 1. Each later accepted sample goes to the next address, and the address wraps from 2^ADDR_W-1 to 0.
- R5: In each period the read address equals that period's write address minus the delay length in effect, modulo 2^ADDR_W. The write happens before the read, so a delay of 0 returns the sample of the same period.
- R6: The delay in effect for the first period after the fill is INIT_DELAY (256). For every later period it is the value on `dly_len` at the close of the previous period. The output is the sample written that many periods earlier, or 0 when no such sample exists.
- R7: `out_left` and `out_right` always carry the same 16-bit value.
- R8: The output holds 0 until the first read after the fill completes. It changes only at the close of a period and stays stable in between.
- R9: An accepted strobe produces exactly one write cycle on the clock after acceptance and one read cycle after that. The output updates on the third clock edge after acceptance. A strobe that arrives before that update is ignored, so strobes must be at least 4 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one clock wide |
| smp_in | input | 16 | Incoming mono sample |
| dly_len | input | ADDR_W | Delay length in samples |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| out_left | output | 16 | Delayed sample, left |
| out_right | output | 16 | Delayed sample, right |
| busy | output | 1 | High during the power-up zero fill |

## Verification
The bench pre-loads the memory model with a non-zero pattern. A design that skipped or shortened the fill, or started it at the wrong address, would leave that pattern in place, and long-delay reads would return it. A strobe is sent in the middle of the fill. If the block accepted it, the first real sample would land at address 2 instead of 1.

Delay 0 catches a design that reads before it writes, because such a design would return stale data rather than the current sample. The delay is changed on every period of a vector table, which exposes a design that applies the new value one period too early or too late. A run past 2^ADDR_W periods with the maximum delay checks the write-address wrap and the read-address underflow. A second strobe sent while a period is still in progress catches a design that double-advances its pointers.

// File: rtl/dl_pkg.sv
package dl_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [2:0] {
        PH_CLEAR   = 3'd0,
        PH_IDLE    = 3'd1,
        PH_WRITE   = 3'd2,
        PH_READ    = 3'd3,
        PH_CAPTURE = 3'd4
    } phase_e;

    typedef struct packed {
        logic adv;       // accepted strobe: advance both pointers
        logic cap;       // close of period: capture data, reload read pointer
        logic clr_step;  // fill pass: step the fill address
    } ctrl_s;

    typedef logic [SAMPLE_W-1:0] sample_t;

endpackage

// File: rtl/dl_seq_ctrl.sv
module dl_seq_ctrl
    import dl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stb,
    input  logic   clr_last,
    output phase_e phase,
    output ctrl_s  ctrl
);

    phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_CLEAR:   if (clr_last) nxt = PH_IDLE;
            PH_IDLE:    if (stb) nxt = PH_WRITE;
            PH_WRITE:   nxt = PH_READ;
            PH_READ:    nxt = PH_CAPTURE;
            PH_CAPTURE: nxt = PH_IDLE;
            default:    nxt = PH_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_CLEAR;
        else     phase <= nxt;
    end

    always_comb begin
        ctrl.adv      = (phase == PH_IDLE) && stb;
        ctrl.cap      = (phase == PH_CAPTURE);
        ctrl.clr_step = (phase == PH_CLEAR);
    end

    // R3: while filling, the only legal successor phases are fill or idle
    a_r3_fill_exit: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CLEAR) |=> (phase == PH_CLEAR || phase == PH_IDLE));

    // R9: a write cycle is always followed by the read cycle
    a_r9_write_then_read: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE) |=> (phase == PH_READ));

endmodule

// File: rtl/dl_ptr_unit.sv
module dl_ptr_unit
    import dl_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int INIT_DELAY = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_s             ctrl,
    input  logic [ADDR_W-1:0] dly,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] clr_ptr,
    output logic              clr_last
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] RD_START = {ADDR_W{1'b0}} - ADDR_W'(INIT_DELAY);

    assign clr_last = (clr_ptr == TOP_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_ptr <= ADDR_W'(1);
        end else if (ctrl.clr_step && !clr_last) begin
            clr_ptr <= clr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= RD_START;
        end else if (ctrl.adv) begin
            wr_ptr <= wr_ptr + 1'b1;
            rd_ptr <= rd_ptr + 1'b1;
        end else if (ctrl.cap) begin
            rd_ptr <= wr_ptr - dly;
        end
    end

endmodule

// File: rtl/dl_out_stage.sv
module dl_out_stage
    import dl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cap,
    input  sample_t rdata,
    output sample_t dout
);

    always_ff @(posedge clk) begin
        if (rst)      dout <= '0;
        else if (cap) dout <= rdata;
    end

endmodule

// File: rtl/dl_delay_seq.sv
module dl_delay_seq
    import dl_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int INIT_DELAY = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [15:0]       smp_in,
    input  logic [ADDR_W-1:0] dly_len,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       out_left,
    output logic [15:0]       out_right,
    output logic              busy
);

    phase_e            phase;
    ctrl_s             ctrl;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr, clr_ptr;
    logic              clr_last;
    sample_t           smp_q;
    sample_t           dout;

    dl_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .clr_last (clr_last),
        .phase    (phase),
        .ctrl     (ctrl)
    );

    dl_ptr_unit #(
        .ADDR_W     (ADDR_W),
        .INIT_DELAY (INIT_DELAY)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .dly      (dly_len),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .clr_ptr  (clr_ptr),
        .clr_last (clr_last)
    );

    dl_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .cap   (ctrl.cap),
        .rdata (mem_rdata),
        .dout  (dout)
    );

    always_ff @(posedge clk) begin
        if (rst)           smp_q <= '0;
        else if (ctrl.adv) smp_q <= smp_in;
    end

    always_comb begin
        mem_addr  = rd_ptr;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (phase)
            PH_CLEAR: begin
                mem_addr = clr_ptr;
                mem_we   = 1'b1;
            end
            PH_WRITE: begin
                mem_addr  = wr_ptr;
                mem_wdata = smp_q;
                mem_we    = 1'b1;
            end
            default: mem_addr = rd_ptr;
        endcase
    end

    assign busy      = (phase == PH_CLEAR);
    assign out_left  = dout;
    assign out_right = dout;

    // Observation state for the assertions below
    logic [ADDR_W-1:0] last_waddr;
    logic [ADDR_W-1:0] dly_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_waddr <= '0;
            dly_seen   <= ADDR_W'(INIT_DELAY);
        end else begin
            if (mem_we && !busy) last_waddr <= mem_addr;
            if (phase == PH_CAPTURE) dly_seen <= dly_len;
        end
    end

    // R2: fill addresses climb by one per clock
    a_r2_fill_ascend: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R2: fill writes carry zero
    a_r2_fill_zero: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_we) |-> (mem_wdata == '0));

    // R4: each sample write lands one word past the previous one
    a_r4_write_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE) |-> (mem_addr == last_waddr + 1'b1));

    // R5: read address is the write address minus the delay in effect
    a_r5_read_offset: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |-> (mem_addr == $past(mem_addr) - dly_seen));

    // R8: output moves only at the close of a period
    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_CAPTURE) |=> $stable(out_left));

    // R9: one write cycle per accepted strobe
    a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WRITE) |=> !mem_we);

endmodule

// File: tb/sim_dl_delay_seq.sv
module sim_dl_delay_seq;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_stb = 1'b0;
    logic [15:0]   smp_in = '0;
    logic [AW-1:0] dly_len = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          mem_we;
    logic [15:0]   mem_rdata;
    logic [15:0]   out_left, out_right;
    logic          busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dl_delay_seq #(.ADDR_W(AW), .INIT_DELAY(256)) u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_in(smp_in),
        .dly_len(dly_len), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .out_left(out_left),
        .out_right(out_right), .busy(busy)
    );

    // Memory model: write at the edge, registered read
    logic [15:0] mem [DEPTH];
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = (i == 0) ? 16'h0000 : 16'hA5A5;
    end
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Monitors on the memory port
    int fill_cnt = 0, fill_first = -1, fill_last = -1, fill_gap = 0;
    int last_waddr = -1, wr_cnt = 0;
    always @(posedge clk) begin
        if (!rst && mem_we && busy) begin
            if (fill_first < 0) fill_first = int'(mem_addr);
            else if (int'(mem_addr) != fill_last + 1) fill_gap++;
            fill_last = int'(mem_addr);
            fill_cnt++;
        end
        if (!rst && mem_we && !busy) begin
            last_waddr = int'(mem_addr);
            wr_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model
    logic [15:0] hist [2048];
    int k = 0;
    int dcur = 256;

    task automatic do_period(input logic [15:0] s, input int d_next, input bit extra, input string req);
        int exp_out, exp_addr, wc0;
        logic [15:0] prev_out;
        prev_out = out_left;
        wc0 = wr_cnt;
        k++;
        hist[k] = s;
        exp_out  = (k - dcur >= 1) ? int'(hist[k - dcur]) : 0;
        exp_addr = k % DEPTH;
        @(negedge clk);
        smp_stb = 1'b1; smp_in = s; dly_len = AW'(d_next);
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
        if (extra) smp_stb = 1'b1;             // arrives during the read cycle
        check("R8", int'(out_left), int'(prev_out), "output mid-period");
        @(negedge clk);
        smp_stb = 1'b0;
        @(negedge clk);
        check(req, int'(out_left), exp_out, "delayed sample");
        check("R7", int'(out_right), int'(out_left), "right equals left");
        check("R4", last_waddr, exp_addr, "write address");
        check("R9", wr_cnt - wc0, 1, "writes per period");
        dcur = d_next;
    endtask

    localparam logic [31:0] VEC [12] = '{
        {16'h1111, 16'd1}, {16'h2222, 16'd3}, {16'h3333, 16'd0},
        {16'h4444, 16'd2}, {16'h5555, 16'd5}, {16'h6666, 16'd4},
        {16'h7777, 16'd1}, {16'h8888, 16'd0}, {16'h9999, 16'd7},
        {16'hAAAA, 16'd2}, {16'hBBBB, 16'd3}, {16'hCCCC, 16'd6}
    };

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(busy), 1, "busy in reset");
        check("R1", int'(out_left), 0, "output in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(busy), 1, "busy after reset");
        check("R1", int'(out_right), 0, "output after reset");

        // R3: strobe in the middle of the fill
        repeat (100) @(negedge clk);
        smp_stb = 1'b1; smp_in = 16'hDEAD;
        @(negedge clk);
        smp_stb = 1'b0;

        for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
        check("R2", int'(busy), 0, "fill finished");
        check("R2", fill_cnt, DEPTH - 1, "fill write count");
        check("R2", fill_first, 1, "first fill address");
        check("R2", fill_last, DEPTH - 1, "last fill address");
        check("R2", fill_gap, 0, "fill address gaps");
        begin
            int nz = 0;
            for (int a = 1; a < DEPTH; a++) if (mem[a] != 16'h0) nz++;
            check("R2", nz, 0, "non-zero words after fill");
        end
        check("R8", int'(out_left), 0, "output before first read");
        check("R3", wr_cnt, 0, "writes from ignored strobe");

        // Vector table: first period uses the initial delay (R6)
        for (int v = 0; v < 12; v++)
            do_period(VEC[v][31:16], int'(VEC[v][15:0]), 1'b0, (v == 0) ? "R6" : "R5");

        // Delay 0 returns the current sample (R5)
        do_period(16'h0F0F, 0, 1'b0, "R5");
        do_period(16'hF0F0, 2, 1'b0, "R5");

        // Second strobe during a period is ignored (R9)
        do_period(16'h1234, 1, 1'b1, "R9");
        do_period(16'h5678, 1, 1'b0, "R9");

        // Maximum delay across the address wrap (R4, R6)
        while (k < 1100) do_period(16'(k * 37 + 5), DEPTH - 1, 1'b0, "R6");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule